// File: doc/BRIEF.md
# Accumulator Core with Vectored Interrupt Entry

This block is a compact 16-bit processor built around one accumulator. It keeps a program counter, a stack pointer, an interrupt-enable flag and a mask register. It drives a single-port, word-addressed memory that holds program, data and stack. Each step fetches one instruction word, decodes it and executes it.

Before every fetch the core checks for a pending interrupt request. If one is pending and interrupts are enabled, that step saves the accumulator and the program counter on a stack in memory that grows downward. It then jumps to the vector that came with the request, and runs no instruction in that step. A return instruction restores both saved values and enables interrupts again.

The core starts halted after reset. A start pulse sets it running, and a stop instruction halts it again. Architectural registers are brought out on observation ports.

Top module: `accu_core`

## Requirements
- R1: After reset the core is halted (`running`=0). The program counter, accumulator and mask are all zero, the stack pointer is 2047 (all ones over 11 bits), and interrupts are enabled (`irq_en_out`=1).
- R2: An instruction word carries its opcode in bits 15..11 and its operand in bits 10..0. Opcode 00001 adds the memory word at the operand address to the accumulator, wrapping modulo 2^16, and advances the program counter by one.
- R3: Opcode 00111 advances the program counter by one and halts the core. While halted, no fetch occurs and no register changes. A one-cycle `start` pulse resumes execution at the current program counter.
- R4: Opcode 01100 loads the mask with the operand, zero-extended to 16 bits. Opcode 01011 clears the mask. Both advance the program counter by one.
- R5: Opcode 01000 clears the interrupt-enable flag and advances the program counter by one.
- R6: A one-cycle `irq_req` pulse latches a pending request together with `irq_vector`. The request stays pending until it is accepted. It is accepted only at the start of a step while the core is running with interrupts enabled; it is never accepted while the core is halted or interrupts are disabled.
- R7: Interrupt entry writes the accumulator at address SP and the program counter at SP-1, lowers SP by 2, clears interrupt enable, loads the program counter with the vector, and executes no instruction in that step.
- R8: Opcode 01101 loads the program counter from address SP+1 and the accumulator from SP+2, raises SP by 2, sets interrupt enable, and execution continues at the restored program counter.
- R9: `mem_we` is asserted only for the two stack writes of an interrupt entry. Programs without an interrupt entry never write memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that resumes a halted core |
| irq_req | input | 1 | One-cycle interrupt request pulse |
| irq_vector | input | 11 | Handler address captured with the request |
| mem_addr | output | 11 | Memory word address |
| mem_rd | output | 1 | Read strobe; data is returned on the next cycle |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, one cycle after `mem_rd` |
| running | output | 1 | 1 while executing, 0 while halted |
| acc_out | output | 16 | Accumulator |
| pc_out | output | 11 | Program counter |
| sp_out | output | 11 | Stack pointer |
| mask_out | output | 16 | Interrupt mask register |
| irq_en_out | output | 1 | Interrupt-enable flag |

## Verification
The assertions assume that memory returns the addressed word exactly one cycle after a read strobe, and that `irq_req` and `start` are single-cycle pulses. The directed bench uses a registered memory model with exactly that one-cycle latency. It changes program words and raises requests only while the core is halted, and it issues each pulse at a falling edge for one cycle. The stack stays far from program and data addresses, so entry writes never overwrite code.

// File: rtl/accu_pkg.sv
package accu_pkg;
  localparam int OPC_W = 5;

  localparam logic [OPC_W-1:0] OPC_ADD  = 5'b00001;
  localparam logic [OPC_W-1:0] OPC_STOP = 5'b00111;
  localparam logic [OPC_W-1:0] OPC_DIS  = 5'b01000;
  localparam logic [OPC_W-1:0] OPC_CZM  = 5'b01011;
  localparam logic [OPC_W-1:0] OPC_MSK  = 5'b01100;
  localparam logic [OPC_W-1:0] OPC_RET  = 5'b01101;

  typedef enum logic [2:0] {
    OP_NOP, OP_ADD, OP_STOP, OP_DIS, OP_CZM, OP_MSK, OP_RET
  } op_e;

  typedef enum logic [3:0] {
    ST_HALT, ST_CHECK, ST_ENT_A, ST_ENT_P, ST_FETCH,
    ST_DECODE, ST_ADD_WB, ST_RET_PC, ST_RET_AC
  } state_e;
endpackage

// File: rtl/accu_rst_sync.sv
module accu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/accu_decode.sv
module accu_decode
  import accu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11
) (
  input  logic [DATA_W-1:0] instr,
  output op_e               op,
  output logic [ADDR_W-1:0] operand
);
  localparam int OPC_LSB = DATA_W - OPC_W;

  logic [OPC_W-1:0] opc;
  assign opc     = instr[DATA_W-1:OPC_LSB];
  assign operand = instr[ADDR_W-1:0];

  always_comb begin
    unique case (opc)
      OPC_ADD:  op = OP_ADD;
      OPC_STOP: op = OP_STOP;
      OPC_DIS:  op = OP_DIS;
      OPC_CZM:  op = OP_CZM;
      OPC_MSK:  op = OP_MSK;
      OPC_RET:  op = OP_RET;
      default:  op = OP_NOP;
    endcase
  end
endmodule

// File: rtl/accu_irq.sv
module accu_irq #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] vector_i,
  input  logic              ack_i,
  output logic              pend_o,
  output logic [ADDR_W-1:0] vec_o
);
  logic              pend_q, pend_d;
  logic [ADDR_W-1:0] vec_q, vec_d;
  logic              vec_en;

  always_comb begin
    pend_d = pend_q;
    vec_d  = vec_q;
    vec_en = req_i && (!pend_q || ack_i);
    if (ack_i) pend_d = 1'b0;
    if (vec_en) begin
      pend_d = 1'b1;
      vec_d  = vector_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      pend_q <= pend_d;
      if (vec_en) vec_q <= vec_d;
    end
  end

  assign pend_o = pend_q;
  assign vec_o  = vec_q;

  // R6: a request is held until the sequencer takes it
  a_r6_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !ack_i) |=> pend_q);
  a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !pend_q) |=> (pend_q && vec_q == $past(vector_i)));
endmodule

// File: rtl/accu_seq.sv
module accu_seq
  import accu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              irq_pend_i,
  input  logic [ADDR_W-1:0] irq_vec_i,
  output logic              irq_ack_o,
  input  op_e               op_i,
  input  logic [ADDR_W-1:0] operand_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              running_o,
  output logic [DATA_W-1:0] acc_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] sp_o,
  output logic [DATA_W-1:0] mask_o,
  output logic              ie_o
);
  localparam int EXT_W = DATA_W - ADDR_W;
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] TWO = ADDR_W'(2);

  state_e            state_q, state_d;
  logic [ADDR_W-1:0] pc_q, pc_d, sp_q, sp_d;
  logic [DATA_W-1:0] acc_q, acc_d, mask_q, mask_d;
  logic              ie_q, ie_d;
  logic              pc_en, sp_en, acc_en, mask_en, ie_en;

  always_comb begin
    state_d     = state_q;
    pc_d        = pc_q;
    sp_d        = sp_q;
    acc_d       = acc_q;
    mask_d      = mask_q;
    ie_d        = ie_q;
    mem_addr_o  = pc_q;
    mem_rd_o    = 1'b0;
    mem_we_o    = 1'b0;
    mem_wdata_o = '0;
    irq_ack_o   = 1'b0;
    unique case (state_q)
      ST_HALT: if (start_i) state_d = ST_CHECK;
      ST_CHECK: state_d = (irq_pend_i && ie_q) ? ST_ENT_A : ST_FETCH;
      ST_ENT_A: begin
        mem_addr_o  = sp_q;
        mem_we_o    = 1'b1;
        mem_wdata_o = acc_q;
        state_d     = ST_ENT_P;
      end
      ST_ENT_P: begin
        mem_addr_o  = sp_q - ONE;
        mem_we_o    = 1'b1;
        mem_wdata_o = {{EXT_W{1'b0}}, pc_q};
        sp_d        = sp_q - TWO;
        pc_d        = irq_vec_i;
        ie_d        = 1'b0;
        irq_ack_o   = 1'b1;
        state_d     = ST_CHECK;
      end
      ST_FETCH: begin
        mem_rd_o = 1'b1;
        state_d  = ST_DECODE;
      end
      ST_DECODE: begin
        pc_d    = pc_q + ONE;
        state_d = ST_CHECK;
        unique case (op_i)
          OP_ADD: begin
            pc_d       = pc_q;
            mem_addr_o = operand_i;
            mem_rd_o   = 1'b1;
            state_d    = ST_ADD_WB;
          end
          OP_STOP: state_d = ST_HALT;
          OP_DIS:  ie_d = 1'b0;
          OP_CZM:  mask_d = '0;
          OP_MSK:  mask_d = {{EXT_W{1'b0}}, operand_i};
          OP_RET: begin
            pc_d       = pc_q;
            mem_addr_o = sp_q + ONE;
            mem_rd_o   = 1'b1;
            state_d    = ST_RET_PC;
          end
          default: ;
        endcase
      end
      ST_ADD_WB: begin
        acc_d   = acc_q + mem_rdata_i;
        pc_d    = pc_q + ONE;
        state_d = ST_CHECK;
      end
      ST_RET_PC: begin
        pc_d       = mem_rdata_i[ADDR_W-1:0];
        mem_addr_o = sp_q + TWO;
        mem_rd_o   = 1'b1;
        state_d    = ST_RET_AC;
      end
      ST_RET_AC: begin
        acc_d   = mem_rdata_i;
        sp_d    = sp_q + TWO;
        ie_d    = 1'b1;
        state_d = ST_CHECK;
      end
      default: state_d = ST_HALT;
    endcase
  end

  assign pc_en   = (state_q == ST_DECODE) || (state_q == ST_ADD_WB) ||
                   (state_q == ST_ENT_P)  || (state_q == ST_RET_PC);
  assign sp_en   = (state_q == ST_ENT_P)  || (state_q == ST_RET_AC);
  assign acc_en  = (state_q == ST_ADD_WB) || (state_q == ST_RET_AC);
  assign mask_en = (state_q == ST_DECODE);
  assign ie_en   = (state_q == ST_DECODE) || (state_q == ST_ENT_P) ||
                   (state_q == ST_RET_AC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HALT;
      pc_q    <= '0;
      sp_q    <= '1;
      acc_q   <= '0;
      mask_q  <= '0;
      ie_q    <= 1'b1;
    end else begin
      state_q <= state_d;
      if (pc_en)   pc_q   <= pc_d;
      if (sp_en)   sp_q   <= sp_d;
      if (acc_en)  acc_q  <= acc_d;
      if (mask_en) mask_q <= mask_d;
      if (ie_en)   ie_q   <= ie_d;
    end
  end

  assign running_o = (state_q != ST_HALT);
  assign acc_o     = acc_q;
  assign pc_o      = pc_q;
  assign sp_o      = sp_q;
  assign mask_o    = mask_q;
  assign ie_o      = ie_q;

  // R2: the add writeback advances the program counter by one
  a_r2_add_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ADD_WB) |=> (pc_q == $past(pc_q) + ONE));
  // R3: a halted core without a start pulse keeps its state
  a_r3_halt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HALT && !start_i) |=>
      (state_q == ST_HALT && $stable(pc_q) && $stable(acc_q) && $stable(sp_q)));
  // R4: the clear-mask opcode leaves a zero mask
  a_r4_mask_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DECODE && op_i == OP_CZM) |=> (mask_q == '0));
  // R6: requests are never taken while interrupts are off
  a_r6_no_take_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CHECK && !ie_q) |=> (state_q == ST_FETCH));
  // R7: entry lowers the stack pointer by two and disables interrupts
  a_r7_entry_stack: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ENT_P) |=> (sp_q == $past(sp_q) - TWO && !ie_q &&
                               pc_q == $past(irq_vec_i)));
  // R8: return raises the stack pointer by two and enables interrupts
  a_r8_return_stack: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RET_AC) |=> (sp_q == $past(sp_q) + TWO && ie_q));
  // R9: memory is written only by the entry sequence
  a_r9_write_entry_only: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> (state_q == ST_ENT_A || state_q == ST_ENT_P));
endmodule

// File: rtl/accu_core.sv
module accu_core
  import accu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              irq_req,
  input  logic [ADDR_W-1:0] irq_vector,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              running,
  output logic [DATA_W-1:0] acc_out,
  output logic [ADDR_W-1:0] pc_out,
  output logic [ADDR_W-1:0] sp_out,
  output logic [DATA_W-1:0] mask_out,
  output logic              irq_en_out
);
  logic              rst_n_s;
  logic              pend, ack;
  logic [ADDR_W-1:0] vec;
  op_e               op;
  logic [ADDR_W-1:0] operand;

  accu_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  accu_irq #(.ADDR_W(ADDR_W)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .req_i    (irq_req),
    .vector_i (irq_vector),
    .ack_i    (ack),
    .pend_o   (pend),
    .vec_o    (vec)
  );

  accu_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dec (
    .instr   (mem_rdata),
    .op      (op),
    .operand (operand)
  );

  accu_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .start_i     (start),
    .irq_pend_i  (pend),
    .irq_vec_i   (vec),
    .irq_ack_o   (ack),
    .op_i        (op),
    .operand_i   (operand),
    .mem_addr_o  (mem_addr),
    .mem_rd_o    (mem_rd),
    .mem_we_o    (mem_we),
    .mem_wdata_o (mem_wdata),
    .mem_rdata_i (mem_rdata),
    .running_o   (running),
    .acc_o       (acc_out),
    .pc_o        (pc_out),
    .sp_o        (sp_out),
    .mask_o      (mask_out),
    .ie_o        (irq_en_out)
  );
endmodule

// File: tb/accu_core_test.sv
module accu_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        irq_req = 1'b0;
  logic [10:0] irq_vector = '0;
  logic [10:0] mem_addr;
  logic        mem_rd, mem_we;
  logic [15:0] mem_wdata, mem_rdata;
  logic        running;
  logic [15:0] acc_out, mask_out;
  logic [10:0] pc_out, sp_out;
  logic        irq_en_out;

  logic [15:0] mem [0:2047];
  int checks = 0, fails = 0, wr_cnt = 0, cyc = 0;

  always #2.5 clk = ~clk;

  accu_core uut (
    .clk(clk), .rst_n(rst_n), .start(start), .irq_req(irq_req),
    .irq_vector(irq_vector), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .running(running), .acc_out(acc_out), .pc_out(pc_out),
    .sp_out(sp_out), .mask_out(mask_out), .irq_en_out(irq_en_out)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    mem_rdata <= mem[mem_addr];
  end

  function automatic logic [15:0] ins(input logic [4:0] opc, input logic [10:0] opd);
    return {opc, opd};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 2048; i++) mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic run_to_halt(input string req);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 500; i++) begin
      if (!running) break;
      @(negedge clk);
    end
    check({req, " halts"}, {31'd0, running}, 32'd0);
  endtask

  task automatic pulse_irq(input logic [10:0] v);
    @(negedge clk);
    irq_req = 1'b1;
    irq_vector = v;
    @(negedge clk);
    irq_req = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 running", {31'd0, running}, 32'd0);
    check("R1 pc", {21'd0, pc_out}, 32'd0);
    check("R1 acc", {16'd0, acc_out}, 32'd0);
    check("R1 mask", {16'd0, mask_out}, 32'd0);
    check("R1 sp", {21'd0, sp_out}, 32'd2047);
    check("R1 ie", {31'd0, irq_en_out}, 32'd1);
  endtask

  task automatic t_add_and_halt();
    int w0;
    w0 = wr_cnt;
    mem[0] = ins(5'b00001, 11'd10);
    mem[1] = ins(5'b00001, 11'd11);
    mem[2] = ins(5'b00111, 11'd0);
    mem[10] = 16'd5;
    mem[11] = 16'hFFFE;
    run_to_halt("R2");
    check("R2 acc wraps", {16'd0, acc_out}, 32'd3);
    check("R3 pc after stop", {21'd0, pc_out}, 32'd3);
    check("R9 no writes", wr_cnt - w0, 32'd0);
    repeat (20) @(negedge clk);
    check("R3 still halted", {31'd0, running}, 32'd0);
    check("R3 pc frozen", {21'd0, pc_out}, 32'd3);
    mem[3] = ins(5'b00001, 11'd12);
    mem[4] = ins(5'b00111, 11'd0);
    mem[12] = 16'd7;
    run_to_halt("R3");
    check("R3 resume acc", {16'd0, acc_out}, 32'd10);
    check("R3 resume pc", {21'd0, pc_out}, 32'd5);
  endtask

  task automatic t_mask();
    do_reset();
    mem[0] = ins(5'b01100, 11'h0FF);
    mem[1] = ins(5'b00111, 11'd0);
    run_to_halt("R4");
    check("R4 mask ff", {16'd0, mask_out}, 32'h00FF);
    mem[2] = ins(5'b01100, 11'h7FF);
    mem[3] = ins(5'b00111, 11'd0);
    run_to_halt("R4");
    check("R4 mask 7ff", {16'd0, mask_out}, 32'h07FF);
    mem[4] = ins(5'b01011, 11'd0);
    mem[5] = ins(5'b00111, 11'd0);
    run_to_halt("R4");
    check("R4 mask cleared", {16'd0, mask_out}, 32'd0);
    check("R4 pc", {21'd0, pc_out}, 32'd6);
  endtask

  task automatic t_irq_round_trip();
    int w0;
    do_reset();
    mem[0] = ins(5'b00001, 11'd10);
    mem[1] = ins(5'b00111, 11'd0);
    mem[2] = ins(5'b00001, 11'd10);
    mem[3] = ins(5'b00111, 11'd0);
    mem[10] = 16'd5;
    mem[100] = ins(5'b00001, 11'd20);
    mem[101] = ins(5'b00111, 11'd0);
    mem[20] = 16'd15;
    run_to_halt("R2");
    check("R2 acc", {16'd0, acc_out}, 32'd5);
    w0 = wr_cnt;
    pulse_irq(11'd100);
    repeat (20) @(negedge clk);
    check("R6 not taken while halted pc", {21'd0, pc_out}, 32'd2);
    check("R6 not taken while halted sp", {21'd0, sp_out}, 32'd2047);
    run_to_halt("R7");
    check("R7 handler pc", {21'd0, pc_out}, 32'd102);
    check("R7 handler acc", {16'd0, acc_out}, 32'd20);
    check("R7 sp lowered", {21'd0, sp_out}, 32'd2045);
    check("R7 ie cleared", {31'd0, irq_en_out}, 32'd0);
    check("R7 saved acc", {16'd0, mem[2047]}, 32'd5);
    check("R7 saved pc", {16'd0, mem[2046]}, 32'd2);
    check("R9 two writes", wr_cnt - w0, 32'd2);
    mem[102] = ins(5'b01101, 11'd0);
    run_to_halt("R8");
    check("R8 resumed pc", {21'd0, pc_out}, 32'd4);
    check("R8 restored acc then add", {16'd0, acc_out}, 32'd10);
    check("R8 sp raised", {21'd0, sp_out}, 32'd2047);
    check("R8 ie set", {31'd0, irq_en_out}, 32'd1);
  endtask

  task automatic t_disable();
    int w0;
    mem[4] = ins(5'b01000, 11'd0);
    mem[5] = ins(5'b00111, 11'd0);
    run_to_halt("R5");
    check("R5 ie cleared", {31'd0, irq_en_out}, 32'd0);
    check("R5 pc", {21'd0, pc_out}, 32'd6);
    w0 = wr_cnt;
    pulse_irq(11'd200);
    mem[6] = ins(5'b00001, 11'd10);
    mem[7] = ins(5'b00111, 11'd0);
    run_to_halt("R6");
    check("R6 disabled: runs program acc", {16'd0, acc_out}, 32'd15);
    check("R6 disabled: pc", {21'd0, pc_out}, 32'd8);
    check("R6 disabled: sp", {21'd0, sp_out}, 32'd2047);
    check("R6 disabled: no writes", wr_cnt - w0, 32'd0);
  endtask

  always @(negedge clk) begin
    if (cyc > 100000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual %0d expected below 100000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_add_and_halt();
    t_mask();
    t_irq_round_trip();
    t_disable();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule